// File: doc/BRIEF.md
# Power-Management Turn-Off Broadcast Controller

This block runs the power-down handshake across a group of downstream ports. Software writes a request bit. The block then asks every enabled port, except one fixed bridge port, to transmit a turn-off message. It also gathers the acknowledgements that come back. When every target port has answered, it raises a status bit that software clears by writing 1. Message encoding and the link layer are handled elsewhere. The block only issues per-port send requests and watches per-port done and acknowledge strobes.

A port whose link sits in the deep sleep state (L2) cannot take a message. Its request is held back until the link returns to L0. While such a port is held back, the control bit stays set and a sticky link-down error is raised. An acknowledgement that arrives on the bridge port is not counted. It is answered with a one-cycle abort pulse instead.

Top module: `turnoff_bcast`

## Requirements
- R1: After reset, sendReq, ctrlBit, ackStatus, linkDownErr and bridgeAbort are all 0.
- R2: A reqWrite pulse while ctrlBit is 0 starts a broadcast. From the next cycle, sendReq is 1 for every port that portEnable enables. The bridge port (index BRIDGE_PORT, default 0) never gets sendReq.
- R3: A target port whose linkInL2 bit is 1 has sendReq 0 until linkInL2 drops. While any target has not sent its message, ctrlBit stays 1.
- R4: ctrlBit is 1 from the cycle after the start until the cycle after the edge at which the last pending port shows sendReq and sendDone together. A port is pending from the start until that happens.
- R5: linkDownErr rises in the cycle after an edge at which a pending target is held in L2. It stays 1 until the next broadcast starts.
- R6: ackStatus rises one cycle after the edge at which the last missing acknowledgement from a target port is registered. ackStatus is 1 only when every target port has acknowledged.
- R7: An ackClrWrite pulse while ackStatus is 1 clears it at the next edge.
- R8: An ackPulse on the bridge port gives a one-cycle bridgeAbort in the next cycle. It does not count toward completion.
- R9: A reqWrite pulse while ctrlBit is 1 has no effect. The pending ports, sendReq and linkDownErr are unchanged.
- R10: If the enabled target set is empty, ctrlBit stays 0 and ackStatus rises one cycle after the start edge.
- R11: Starting a broadcast clears ackStatus, linkDownErr and all per-port acknowledged flags.
- R12: An acknowledgement on a target port counts only if that port's message was sent at an earlier edge. An acknowledgement that arrives before its message has been sent is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqWrite | input | 1 | Software writes 1 to the control bit (pulse) |
| ackClrWrite | input | 1 | Software writes 1 to clear the status bit (pulse) |
| portEnable | input | NUM_PORTS | Per-port enable mask |
| linkInL2 | input | NUM_PORTS | Per-port flag, 1 = link is in L2 |
| sendDone | input | NUM_PORTS | Per-port message-sent handshake |
| ackPulse | input | NUM_PORTS | Per-port acknowledge received (pulse) |
| sendReq | output | NUM_PORTS | Per-port request to send the turn-off message |
| ctrlBit | output | 1 | Control bit as software reads it (1 = broadcast in progress) |
| ackStatus | output | 1 | All-acknowledged status bit |
| linkDownErr | output | 1 | Sticky error flag: a message was held back in L2 |
| bridgeAbort | output | 1 | One-cycle abort for an acknowledge on the bridge port |

## Verification
A pending flag left stuck high keeps ctrlBit at 1 and leaves the port's sendReq asserted. The per-cycle compare sees both in the first cycle after the expected send edge. An acknowledged flag set too early or too late makes ackStatus rise one cycle early or hang at 0, so the status compare flags it at the cycle it should change. A target mask that takes in the bridge port, or drops an enabled port, shows up as a wrong sendReq bit in the first cycle after the start.

// File: rtl/turnoff_bcast_pkg.sv
package turnoff_bcast_pkg;

  // Strobes from the control half to the per-port datapath.
  typedef struct packed {
    logic start;      // load a fresh target set this edge
    logic ackWindow;  // acknowledgements are being collected
  } ctrlStrobe_t;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_t;

endpackage

// File: rtl/turnoff_bcast_dp.sv
module turnoff_bcast_dp
  import turnoff_bcast_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int BRIDGE_PORT = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] linkInL2,
  input  logic [NUM_PORTS-1:0] sendDone,
  input  logic [NUM_PORTS-1:0] ackPulse,
  output logic [NUM_PORTS-1:0] sendReq,
  output logic                 pendAny,
  output logic                 heldAny,
  output logic                 allAcked,
  output logic                 bridgeAbort
);

  logic [NUM_PORTS-1:0] pendQ;
  logic [NUM_PORTS-1:0] ackedQ;
  logic [NUM_PORTS-1:0] targetQ;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    if (i == BRIDGE_PORT) begin : g_bridge
      // The bridge port is never a target.
      assign pendQ[i]   = 1'b0;
      assign ackedQ[i]  = 1'b0;
      assign targetQ[i] = 1'b0;
      assign sendReq[i] = 1'b0;
    end else begin : g_target
      logic pendBit;
      logic sentBit;
      logic ackedBit;
      logic tgtBit;
      logic fireNow;

      assign fireNow = pendBit && !linkInL2[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pendBit  <= 1'b0;
          sentBit  <= 1'b0;
          ackedBit <= 1'b0;
          tgtBit   <= 1'b0;
        end else if (strobe.start) begin
          tgtBit   <= portEnable[i];
          pendBit  <= portEnable[i];
          sentBit  <= 1'b0;
          ackedBit <= 1'b0;
        end else begin
          if (fireNow && sendDone[i]) begin
            pendBit <= 1'b0;
            sentBit <= 1'b1;
          end
          if (strobe.ackWindow && ackPulse[i] && sentBit && tgtBit) begin
            ackedBit <= 1'b1;
          end
        end
      end

      assign pendQ[i]   = pendBit;
      assign ackedQ[i]  = ackedBit;
      assign targetQ[i] = tgtBit;
      assign sendReq[i] = fireNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bridgeAbort <= 1'b0;
    else       bridgeAbort <= ackPulse[BRIDGE_PORT];
  end

  assign pendAny  = |pendQ;
  assign heldAny  = |(pendQ & linkInL2);
  assign allAcked = ((ackedQ & targetQ) == targetQ);

  logic unusedBridgeIn;
  assign unusedBridgeIn = sendDone[BRIDGE_PORT] ^ portEnable[BRIDGE_PORT];

endmodule

// File: rtl/turnoff_bcast_ctrl.sv
module turnoff_bcast_ctrl
  import turnoff_bcast_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqWrite,
  input  logic        ackClrWrite,
  input  logic        pendAny,
  input  logic        heldAny,
  input  logic        allAcked,
  output ctrlStrobe_t strobe,
  output logic        ackStatus,
  output logic        linkDownErr
);

  phase_t phaseQ;
  logic   startNow;

  // A write while messages are still pending is dropped.
  assign startNow = reqWrite && !pendAny;

  always_comb begin
    strobe.start     = startNow;
    strobe.ackWindow = (phaseQ == PH_ACTIVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ      <= PH_IDLE;
      ackStatus   <= 1'b0;
      linkDownErr <= 1'b0;
    end else if (startNow) begin
      phaseQ      <= PH_ACTIVE;
      ackStatus   <= 1'b0;
      linkDownErr <= 1'b0;
    end else begin
      if (phaseQ == PH_ACTIVE && allAcked) begin
        ackStatus <= 1'b1;
        phaseQ    <= PH_IDLE;
      end else if (ackClrWrite) begin
        ackStatus <= 1'b0;
      end
      if (heldAny) linkDownErr <= 1'b1;
    end
  end

endmodule

// File: rtl/turnoff_bcast.sv
module turnoff_bcast
  import turnoff_bcast_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int BRIDGE_PORT = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqWrite,
  input  logic                 ackClrWrite,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] linkInL2,
  input  logic [NUM_PORTS-1:0] sendDone,
  input  logic [NUM_PORTS-1:0] ackPulse,
  output logic [NUM_PORTS-1:0] sendReq,
  output logic                 ctrlBit,
  output logic                 ackStatus,
  output logic                 linkDownErr,
  output logic                 bridgeAbort
);

  ctrlStrobe_t strobe;
  logic        pendAny;
  logic        heldAny;
  logic        allAcked;

  turnoff_bcast_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqWrite   (reqWrite),
    .ackClrWrite(ackClrWrite),
    .pendAny    (pendAny),
    .heldAny    (heldAny),
    .allAcked   (allAcked),
    .strobe     (strobe),
    .ackStatus  (ackStatus),
    .linkDownErr(linkDownErr)
  );

  turnoff_bcast_dp #(
    .NUM_PORTS  (NUM_PORTS),
    .BRIDGE_PORT(BRIDGE_PORT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .portEnable (portEnable),
    .linkInL2   (linkInL2),
    .sendDone   (sendDone),
    .ackPulse   (ackPulse),
    .sendReq    (sendReq),
    .pendAny    (pendAny),
    .heldAny    (heldAny),
    .allAcked   (allAcked),
    .bridgeAbort(bridgeAbort)
  );

  assign ctrlBit = pendAny;

endmodule

// File: rtl/turnoff_bcast_chk.sv
module turnoff_bcast_chk #(
  parameter int NUM_PORTS   = 4,
  parameter int BRIDGE_PORT = 0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqWrite,
  input logic                 ackClrWrite,
  input logic [NUM_PORTS-1:0] portEnable,
  input logic [NUM_PORTS-1:0] linkInL2,
  input logic [NUM_PORTS-1:0] sendDone,
  input logic [NUM_PORTS-1:0] ackPulse,
  input logic [NUM_PORTS-1:0] sendReq,
  input logic                 ctrlBit,
  input logic                 ackStatus,
  input logic                 linkDownErr,
  input logic                 bridgeAbort
);

  logic unusedChkIn;
  assign unusedChkIn = reqWrite ^ (|portEnable);

  a_r2_no_bridge_send: assert property (@(posedge clk) disable iff (!rstN)
    !sendReq[BRIDGE_PORT]);

  a_r3_no_send_in_l2: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq & linkInL2) == '0);

  a_r4_ctrl_falls_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlBit) |-> $past(|(sendReq & sendDone)));

  a_r5_err_sticky_busy: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBit |=> !$fell(linkDownErr));

  a_r6_ack_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    ackStatus |-> !ctrlBit);

  a_r7_clear_status: assert property (@(posedge clk) disable iff (!rstN)
    (ackStatus && ackClrWrite) |=> !ackStatus);

  a_r8_bridge_abort: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse[BRIDGE_PORT] |=> bridgeAbort);

endmodule

bind turnoff_bcast turnoff_bcast_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .BRIDGE_PORT(BRIDGE_PORT)
) u_chk (.*);

// File: tb/turnoff_bcast_tb.sv
module turnoff_bcast_tb;
  localparam int NP = 4;
  localparam int BR = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqWrite = 1'b0;
  logic ackClrWrite = 1'b0;
  logic [NP-1:0] portEnable = '0;
  logic [NP-1:0] linkInL2 = '0;
  logic [NP-1:0] sendDone = '0;
  logic [NP-1:0] ackPulse = '0;
  logic [NP-1:0] sendReq;
  logic ctrlBit, ackStatus, linkDownErr, bridgeAbort;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  turnoff_bcast #(.NUM_PORTS(NP), .BRIDGE_PORT(BR)) u_dut (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .ackClrWrite(ackClrWrite),
    .portEnable(portEnable), .linkInL2(linkInL2), .sendDone(sendDone),
    .ackPulse(ackPulse), .sendReq(sendReq), .ctrlBit(ctrlBit),
    .ackStatus(ackStatus), .linkDownErr(linkDownErr), .bridgeAbort(bridgeAbort)
  );

  // Behavioural reference model.
  logic [NP-1:0] mPend, mSent, mAcked, mTarget;
  logic mCollect, mAck, mErr, mAbort;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mSent = '0; mAcked = '0; mTarget = '0;
      mCollect = 0; mAck = 0; mErr = 0; mAbort = 0;
    end else begin
      logic [NP-1:0] oPend, oSent, oAcked, tgt;
      logic oCollect;
      oPend = mPend; oSent = mSent; oAcked = mAcked; oCollect = mCollect;
      if (reqWrite && oPend == '0) begin
        tgt = portEnable;
        tgt[BR] = 1'b0;
        mPend = tgt; mTarget = tgt; mSent = '0; mAcked = '0;
        mCollect = 1; mAck = 0; mErr = 0;
      end else begin
        if (oCollect && (oAcked & mTarget) == mTarget) begin
          mAck = 1; mCollect = 0;
        end else if (ackClrWrite) begin
          mAck = 0;
        end
        if ((oPend & linkInL2) != '0) mErr = 1;
        for (int i = 0; i < NP; i++) begin
          if (oPend[i] && !linkInL2[i] && sendDone[i]) begin
            mPend[i] = 0; mSent[i] = 1;
          end
          if (oCollect && ackPulse[i] && oSent[i] && mTarget[i]) mAcked[i] = 1;
        end
      end
      mAbort = ackPulse[BR];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle compare against the model.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 sendReq vs model", 32'(sendReq), 32'(mPend & ~linkInL2));
      chk("R4 ctrlBit vs model", 32'(ctrlBit), 32'(mPend != '0));
      chk("R6 ackStatus vs model", 32'(ackStatus), 32'(mAck));
      chk("R5 linkDownErr vs model", 32'(linkDownErr), 32'(mErr));
      chk("R8 bridgeAbort vs model", 32'(bridgeAbort), 32'(mAbort));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R1 reset sendReq", 32'(sendReq), 0);
    chk("R1 reset ctrlBit", 32'(ctrlBit), 0);
    chk("R1 reset ackStatus", 32'(ackStatus), 0);
    chk("R1 reset linkDownErr", 32'(linkDownErr), 0);
    chk("R1 reset bridgeAbort", 32'(bridgeAbort), 0);
    step();
    rstN = 1'b1;
    step();

    // Plain broadcast, all links up.
    portEnable = 4'b1111;
    reqWrite = 1; step(); reqWrite = 0;
    @(negedge clk);
    chk("R2 targets exclude bridge", 32'(sendReq), 32'(4'b1110));
    ackPulse = 4'b0010; step(); ackPulse = 0;       // early ack, dropped
    sendDone = 4'b1110; step(); sendDone = 0;
    @(negedge clk);
    chk("R4 ctrlBit clears after last send", 32'(ctrlBit), 0);
    ackPulse = 4'b0100; step(); ackPulse = 4'b0001; step(); ackPulse = 0;
    @(negedge clk);
    chk("R8 bridge ack aborted", 32'(bridgeAbort), 1);
    ackPulse = 4'b1000; step(); ackPulse = 0; step();
    @(negedge clk);
    chk("R12 early ack not counted", 32'(ackStatus), 0);
    ackPulse = 4'b0010; step(); ackPulse = 0;
    @(negedge clk);
    chk("R6 status not before next edge", 32'(ackStatus), 0);
    step();
    @(negedge clk);
    chk("R6 status after all acks", 32'(ackStatus), 1);
    ackClrWrite = 1; step(); ackClrWrite = 0;
    @(negedge clk);
    chk("R7 write-1 clears status", 32'(ackStatus), 0);

    // Port 2 asleep in L2.
    linkInL2 = 4'b0100;
    reqWrite = 1; step(); reqWrite = 0;
    @(negedge clk);
    chk("R3 held port not requested", 32'(sendReq), 32'(4'b1010));
    step();
    @(negedge clk);
    chk("R5 error raised for held port", 32'(linkDownErr), 1);
    sendDone = 4'b1010; step(); sendDone = 0;
    @(negedge clk);
    chk("R3 ctrlBit stays while held", 32'(ctrlBit), 1);
    portEnable = 4'b0010;
    reqWrite = 1; step(); reqWrite = 0;
    @(negedge clk);
    chk("R9 busy write keeps error", 32'(linkDownErr), 1);
    chk("R9 busy write keeps pending set", 32'(sendReq), 0);
    portEnable = 4'b1111;
    linkInL2 = 4'b0000;
    @(negedge clk);
    chk("R3 request after L0 return", 32'(sendReq), 32'(4'b0100));
    sendDone = 4'b0100; step(); sendDone = 0;
    @(negedge clk);
    chk("R4 ctrlBit clears when held port sent", 32'(ctrlBit), 0);

    // Only the bridge enabled: empty target set.
    portEnable = 4'b0001;
    reqWrite = 1; step(); reqWrite = 0;
    @(negedge clk);
    chk("R10 ctrlBit stays 0", 32'(ctrlBit), 0);
    chk("R11 start clears error", 32'(linkDownErr), 0);
    chk("R10 status not yet", 32'(ackStatus), 0);
    step();
    @(negedge clk);
    chk("R10 status one cycle later", 32'(ackStatus), 1);

    // New broadcast clears stale status and acked flags.
    portEnable = 4'b0110;
    reqWrite = 1; step(); reqWrite = 0;
    @(negedge clk);
    chk("R11 start clears status", 32'(ackStatus), 0);
    chk("R2 second target set", 32'(sendReq), 32'(4'b0110));
    sendDone = 4'b0110; step(); sendDone = 0;
    ackPulse = 4'b0010; step(); ackPulse = 0; step();
    @(negedge clk);
    chk("R11 acked flags cleared at start", 32'(ackStatus), 0);
    ackPulse = 4'b0100; step(); ackPulse = 0; step();
    @(negedge clk);
    chk("R6 status after second set", 32'(ackStatus), 1);

    step();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule